// File: doc/BRIEF.md
# Doorbell Channel Window

This block is one doorbell channel that links a sending agent and a receiving agent. Each agent has its own small register port: a select, a write strobe, a word address and a data word. The channel keeps a word of independent doorbell flags. The sender raises flags by writing ones. The receiver sees those flags through a per-flag mask and retires them by writing ones to a clear register.

When the receiver retires a pending flag, the sender gets a sticky transfer-acknowledge status. An enable turns that status into the sender's interrupt. The receiver's interrupt is high while any unmasked flag is pending. Software on the sending side can also poll the flag word: a flag reads back as 0 once the receiver has consumed it.

All register writes take effect at the clock edge where select and write are both high. Read data is combinational from the address while select is high, and 0 while select is low.

Top module: `dbell_chan_window`

## Requirements
- R1: After reset, all flags are 0, every mask bit is 1, the acknowledge status, acknowledge enable and both control bits are 0, and both interrupts are low.
- R2: The sender reads the flag word at offset 0x00. Writing to offset 0x0C sets each flag whose data bit is 1; data bits of 0 leave their flag unchanged.
- R3: The receiver reads the flag word at offset 0x00. Writing to offset 0x08 clears each flag whose data bit is 1; data bits of 0 have no effect.
- R4: The receiver reads the masked view, flags AND NOT mask, at offset 0x04.
- R5: The receiver reads the mask at offset 0x10. Writing ones to offset 0x14 sets mask bits, and writing ones to offset 0x18 clears them. Zero bits have no effect.
- R6: A receiver clear that turns at least one flag from 1 to 0 sets the acknowledge status, read as bit 0 of sender offset 0x10, one cycle later. The status stays set until cleared. A clear that hits only flags already at 0 does not set it.
- R7: Writing a word with bit 0 set to sender offset 0x14 clears the acknowledge status. If an acknowledge event occurs in the same cycle, the status stays set.
- R8: The sender interrupt equals the acknowledge status ANDed with the enable, which is bit 0 of sender offset 0x18 (read/write).
- R9: The receiver interrupt is high exactly when some bit of the masked view is 1.
- R10: If a set and a clear hit the same flag in the same cycle, the flag ends at 1 and that flag raises no acknowledge event.
- R11: Each side has a control bit at bit 0 of offset 0x1C, readable and writable. All higher bits read 0.
- R12: Unmapped offsets read 0, and read data is 0 while select is low. Writes to read-only offsets (sender 0x00 and 0x10; receiver 0x00, 0x04 and 0x10) change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_sel | input | 1 | Sender port select |
| tx_wr | input | 1 | Sender write strobe |
| tx_addr | input | ADDR_W | Sender byte offset |
| tx_wdata | input | FLAG_W | Sender write data |
| tx_rdata | output | FLAG_W | Sender read data |
| rx_sel | input | 1 | Receiver port select |
| rx_wr | input | 1 | Receiver write strobe |
| rx_addr | input | ADDR_W | Receiver byte offset |
| rx_wdata | input | FLAG_W | Receiver write data |
| rx_rdata | output | FLAG_W | Receiver read data |
| tx_irq | output | 1 | Sender transfer-acknowledge interrupt |
| rx_irq | output | 1 | Receiver pending-doorbell interrupt |

## Verification
The embedded properties assume that the write data is a known value whenever select and write are high. They also assume the two ports may write in the same cycle, but that one port never targets two registers at once. The stimulus keeps to this because every input is driven from a task one time unit after the rising edge. Both ports are driven in the same cycle only to exercise the set-versus-clear and clear-versus-event collisions. The random phase draws only mapped offsets plus a few unmapped ones, and always draws fully defined data.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  localparam int unsigned FLAG_W_DEF = 32;
  localparam int unsigned ADDR_W_DEF = 5;

  // sender side offsets
  localparam int unsigned TX_STAT = 32'h00;
  localparam int unsigned TX_SET  = 32'h0C;
  localparam int unsigned TX_AST  = 32'h10;
  localparam int unsigned TX_ACLR = 32'h14;
  localparam int unsigned TX_AEN  = 32'h18;
  localparam int unsigned TX_CTL  = 32'h1C;

  // receiver side offsets
  localparam int unsigned RX_STAT = 32'h00;
  localparam int unsigned RX_MSTA = 32'h04;
  localparam int unsigned RX_CLR  = 32'h08;
  localparam int unsigned RX_MASK = 32'h10;
  localparam int unsigned RX_MSET = 32'h14;
  localparam int unsigned RX_MCLR = 32'h18;
  localparam int unsigned RX_CTL  = 32'h1C;
endpackage

// File: rtl/dbell_flag_store.sv
module dbell_flag_store #(
  parameter int unsigned FLAG_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] set_vec,
  input  logic [FLAG_W-1:0] clr_vec,
  output logic [FLAG_W-1:0] flags,
  output logic              ack_evt
);
  logic [FLAG_W-1:0] flags_nxt;
  logic              flags_en;

  always_comb begin
    flags_en  = (|set_vec) | (|clr_vec);
    flags_nxt = (flags & ~clr_vec) | set_vec;
    ack_evt   = |(flags & clr_vec & ~set_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags <= '0;
    else if (flags_en) flags <= flags_nxt;
  end

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((flags & $past(set_vec)) == $past(set_vec)));

  // R3
  clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~set_vec)) |=> ((flags & $past(clr_vec & ~set_vec)) == '0));
endmodule

// File: rtl/dbell_tx_port.sv
module dbell_tx_port
  import dbell_pkg::*;
#(
  parameter int unsigned FLAG_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [FLAG_W-1:0] wdata,
  input  logic [FLAG_W-1:0] flags,
  input  logic              ack_evt,
  output logic [FLAG_W-1:0] rdata,
  output logic [FLAG_W-1:0] set_vec,
  output logic              irq
);
  logic ack_st, ack_en, ctl_en;
  logic ack_st_nxt, ack_en_nxt, ctl_en_nxt;
  logic wr_hit, ack_clr, en_we, ctl_we;
  logic [31:0] ofs;

  always_comb begin
    ofs     = 32'(addr);
    wr_hit  = sel & wr;
    set_vec = (wr_hit && ofs == TX_SET) ? wdata : '0;
    ack_clr = wr_hit && ofs == TX_ACLR && wdata[0];
    en_we   = wr_hit && ofs == TX_AEN;
    ctl_we  = wr_hit && ofs == TX_CTL;
    if (ack_evt)      ack_st_nxt = 1'b1;
    else if (ack_clr) ack_st_nxt = 1'b0;
    else              ack_st_nxt = ack_st;
    ack_en_nxt = en_we  ? wdata[0] : ack_en;
    ctl_en_nxt = ctl_we ? wdata[0] : ctl_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_st <= 1'b0;
      ack_en <= 1'b0;
      ctl_en <= 1'b0;
    end else begin
      ack_st <= ack_st_nxt;
      if (en_we)  ack_en <= ack_en_nxt;
      if (ctl_we) ctl_en <= ctl_en_nxt;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel) begin
      case (ofs)
        TX_STAT: rdata = flags;
        TX_AST:  rdata = FLAG_W'(ack_st);
        TX_AEN:  rdata = FLAG_W'(ack_en);
        TX_CTL:  rdata = FLAG_W'(ctl_en);
        default: rdata = '0;
      endcase
    end
  end

  assign irq = ack_st & ack_en;

  // R6
  ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_evt |=> ack_st);

  // R6
  ack_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_st && !(sel && wr && ofs == TX_ACLR && wdata[0])) |=> ack_st);
endmodule

// File: rtl/dbell_rx_port.sv
module dbell_rx_port
  import dbell_pkg::*;
#(
  parameter int unsigned FLAG_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [FLAG_W-1:0] wdata,
  input  logic [FLAG_W-1:0] flags,
  output logic [FLAG_W-1:0] rdata,
  output logic [FLAG_W-1:0] clr_vec,
  output logic              irq
);
  logic [FLAG_W-1:0] mask, mask_nxt, masked;
  logic              ctl_en, ctl_en_nxt;
  logic              wr_hit, mset_we, mclr_we, mask_we, ctl_we;
  logic [31:0]       ofs;

  always_comb begin
    ofs      = 32'(addr);
    wr_hit   = sel & wr;
    clr_vec  = (wr_hit && ofs == RX_CLR) ? wdata : '0;
    mset_we  = wr_hit && ofs == RX_MSET;
    mclr_we  = wr_hit && ofs == RX_MCLR;
    mask_we  = mset_we | mclr_we;
    ctl_we   = wr_hit && ofs == RX_CTL;
    mask_nxt = mset_we ? (mask | wdata) : (mask & ~wdata);
    ctl_en_nxt = ctl_we ? wdata[0] : ctl_en;
    masked   = flags & ~mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask   <= '1;
      ctl_en <= 1'b0;
    end else begin
      if (mask_we) mask   <= mask_nxt;
      if (ctl_we)  ctl_en <= ctl_en_nxt;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel) begin
      case (ofs)
        RX_STAT: rdata = flags;
        RX_MSTA: rdata = masked;
        RX_MASK: rdata = mask;
        RX_CTL:  rdata = FLAG_W'(ctl_en);
        default: rdata = '0;
      endcase
    end
  end

  assign irq = |masked;

  // R5
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && ofs == RX_MSET) |=> ((mask & $past(wdata)) == $past(wdata)));

  // R5
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && ofs == RX_MCLR) |=> ((mask & $past(wdata)) == '0));
endmodule

// File: rtl/dbell_chan_window.sv
module dbell_chan_window
  import dbell_pkg::*;
#(
  parameter int unsigned FLAG_W = FLAG_W_DEF,
  parameter int unsigned ADDR_W = ADDR_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_sel,
  input  logic              tx_wr,
  input  logic [ADDR_W-1:0] tx_addr,
  input  logic [FLAG_W-1:0] tx_wdata,
  output logic [FLAG_W-1:0] tx_rdata,
  input  logic              rx_sel,
  input  logic              rx_wr,
  input  logic [ADDR_W-1:0] rx_addr,
  input  logic [FLAG_W-1:0] rx_wdata,
  output logic [FLAG_W-1:0] rx_rdata,
  output logic              tx_irq,
  output logic              rx_irq
);
  logic [FLAG_W-1:0] flags, set_vec, clr_vec;
  logic              ack_evt;

  dbell_flag_store #(.FLAG_W(FLAG_W)) store_i (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .flags(flags), .ack_evt(ack_evt)
  );

  dbell_tx_port #(.FLAG_W(FLAG_W), .ADDR_W(ADDR_W)) tx_i (
    .clk(clk), .rst_n(rst_n), .sel(tx_sel), .wr(tx_wr), .addr(tx_addr),
    .wdata(tx_wdata), .flags(flags), .ack_evt(ack_evt), .rdata(tx_rdata),
    .set_vec(set_vec), .irq(tx_irq)
  );

  dbell_rx_port #(.FLAG_W(FLAG_W), .ADDR_W(ADDR_W)) rx_i (
    .clk(clk), .rst_n(rst_n), .sel(rx_sel), .wr(rx_wr), .addr(rx_addr),
    .wdata(rx_wdata), .flags(flags), .rdata(rx_rdata), .clr_vec(clr_vec),
    .irq(rx_irq)
  );
endmodule

// File: tb/dbell_chan_window_tb_top.sv
module dbell_chan_window_tb_top;
  localparam int FW = 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tx_sel = 0, tx_wr = 0, rx_sel = 0, rx_wr = 0;
  logic [AW-1:0] tx_addr = '0, rx_addr = '0;
  logic [FW-1:0] tx_wdata = '0, rx_wdata = '0;
  logic [FW-1:0] tx_rdata, rx_rdata;
  logic          tx_irq, rx_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference state
  logic [FW-1:0] m_flags, m_mask;
  logic          m_ast, m_aen, m_tctl, m_rctl;

  always #4 clk = ~clk;

  dbell_chan_window #(.FLAG_W(FW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .tx_sel(tx_sel), .tx_wr(tx_wr), .tx_addr(tx_addr), .tx_wdata(tx_wdata), .tx_rdata(tx_rdata),
    .rx_sel(rx_sel), .rx_wr(rx_wr), .rx_addr(rx_addr), .rx_wdata(rx_wdata), .rx_rdata(rx_rdata),
    .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flags = '0; m_mask = '1; m_ast = 0; m_aen = 0; m_tctl = 0; m_rctl = 0;
    end else begin
      logic [FW-1:0] s, c;
      logic ev;
      s  = (tx_sel && tx_wr && tx_addr == 5'h0C) ? tx_wdata : '0;
      c  = (rx_sel && rx_wr && rx_addr == 5'h08) ? rx_wdata : '0;
      ev = |(m_flags & c & ~s);
      m_flags = (m_flags & ~c) | s;
      if (ev) m_ast = 1;
      else if (tx_sel && tx_wr && tx_addr == 5'h14 && tx_wdata[0]) m_ast = 0;
      if (tx_sel && tx_wr && tx_addr == 5'h18) m_aen = tx_wdata[0];
      if (tx_sel && tx_wr && tx_addr == 5'h1C) m_tctl = tx_wdata[0];
      if (rx_sel && rx_wr && rx_addr == 5'h14) m_mask = m_mask | rx_wdata;
      if (rx_sel && rx_wr && rx_addr == 5'h18) m_mask = m_mask & ~rx_wdata;
      if (rx_sel && rx_wr && rx_addr == 5'h1C) m_rctl = rx_wdata[0];
    end
  end

  function automatic logic [FW-1:0] exp_tx(input logic sel, input logic [AW-1:0] a);
    if (!sel) return '0;
    case (a)
      5'h00: return m_flags;
      5'h10: return FW'(m_ast);
      5'h18: return FW'(m_aen);
      5'h1C: return FW'(m_tctl);
      default: return '0;
    endcase
  endfunction

  function automatic logic [FW-1:0] exp_rx(input logic sel, input logic [AW-1:0] a);
    if (!sel) return '0;
    case (a)
      5'h00: return m_flags;
      5'h04: return m_flags & ~m_mask;
      5'h10: return m_mask;
      5'h1C: return FW'(m_rctl);
      default: return '0;
    endcase
  endfunction

  function automatic string tx_tag(input logic [AW-1:0] a);
    case (a)
      5'h00: return "R2";
      5'h10: return "R6";
      5'h18: return "R8";
      5'h1C: return "R11";
      default: return "R12";
    endcase
  endfunction

  function automatic string rx_tag(input logic [AW-1:0] a);
    case (a)
      5'h00: return "R3";
      5'h04: return "R4";
      5'h10: return "R5";
      5'h1C: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string tag, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(tx_tag(tx_addr), tx_rdata, exp_tx(tx_sel, tx_addr));
      check(rx_tag(rx_addr), rx_rdata, exp_rx(rx_sel, rx_addr));
      check("R8", FW'(tx_irq), FW'(m_ast & m_aen));
      check("R9", FW'(rx_irq), FW'(|(m_flags & ~m_mask)));
    end
  end

  task automatic idle();
    tx_sel = 0; tx_wr = 0; rx_sel = 0; rx_wr = 0;
  endtask

  task automatic both_wr(input bit dt, input logic [AW-1:0] ta, input logic [FW-1:0] td,
                         input bit dr, input logic [AW-1:0] ra, input logic [FW-1:0] rd);
    @(posedge clk); #1;
    tx_sel = dt; tx_wr = dt; tx_addr = ta; tx_wdata = td;
    rx_sel = dr; rx_wr = dr; rx_addr = ra; rx_wdata = rd;
    @(posedge clk); #1;
    idle();
  endtask

  task automatic tx_write(input logic [AW-1:0] a, input logic [FW-1:0] d);
    both_wr(1, a, d, 0, '0, '0);
  endtask

  task automatic rx_write(input logic [AW-1:0] a, input logic [FW-1:0] d);
    both_wr(0, '0, '0, 1, a, d);
  endtask

  task automatic peek_tx(input logic [AW-1:0] a, input logic [FW-1:0] exp, input string tag);
    @(posedge clk); #1;
    tx_sel = 1; tx_wr = 0; tx_addr = a;
    @(negedge clk);
    check(tag, tx_rdata, exp);
  endtask

  task automatic peek_rx(input logic [AW-1:0] a, input logic [FW-1:0] exp, input string tag);
    @(posedge clk); #1;
    rx_sel = 1; rx_wr = 0; rx_addr = a;
    @(negedge clk);
    check(tag, rx_rdata, exp);
  endtask

  function automatic logic [AW-1:0] pick_addr(input int r);
    case (r % 10)
      0: return 5'h00; 1: return 5'h04; 2: return 5'h08; 3: return 5'h0C;
      4: return 5'h10; 5: return 5'h14; 6: return 5'h18; 7: return 5'h1C;
      8: return 5'h0C; default: return 5'h08;
    endcase
  endfunction

  initial begin
    #(8 * 50000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    peek_tx(5'h00, '0, "R1");
    peek_tx(5'h10, '0, "R1");
    peek_tx(5'h18, '0, "R1");
    peek_tx(5'h1C, '0, "R1");
    peek_rx(5'h10, 32'hFFFF_FFFF, "R1");
    peek_rx(5'h1C, '0, "R1");
    check("R1", FW'(tx_irq), '0);
    check("R1", FW'(rx_irq), '0);
    idle();

    // R2 set flags, zero bits ignored
    tx_write(5'h0C, 32'h0000_00A5);
    peek_tx(5'h00, 32'h0000_00A5, "R2");
    tx_write(5'h0C, 32'h0);
    tx_write(5'h00, 32'hFFFF_0000);            // R12 read-only
    peek_tx(5'h00, 32'h0000_00A5, "R12");
    peek_rx(5'h00, 32'h0000_00A5, "R3");
    peek_rx(5'h04, 32'h0, "R4");
    idle();

    // R5 mask clear / set, R9 irq
    rx_write(5'h18, 32'h0000_000F);
    peek_rx(5'h10, 32'hFFFF_FFF0, "R5");
    peek_rx(5'h04, 32'h0000_0005, "R4");
    check("R9", FW'(rx_irq), FW'(1));
    rx_write(5'h14, 32'h0000_0001);
    peek_rx(5'h04, 32'h0000_0004, "R4");
    idle();

    // R6 / R8 acknowledge path
    tx_write(5'h18, 32'h1);
    rx_write(5'h08, 32'h0000_0004);
    peek_tx(5'h10, 32'h1, "R6");
    check("R8", FW'(tx_irq), FW'(1));
    peek_tx(5'h00, 32'h0000_00A1, "R2");
    check("R9", FW'(rx_irq), '0);
    tx_write(5'h14, 32'h1);                    // R7 clear
    peek_tx(5'h10, 32'h0, "R7");
    rx_write(5'h08, 32'h0000_0002);            // already 0: no event
    peek_tx(5'h10, 32'h0, "R6");

    // R7 event and clear in the same cycle
    both_wr(1, 5'h14, 32'h1, 1, 5'h08, 32'h0000_0001);
    peek_tx(5'h10, 32'h1, "R7");
    tx_write(5'h14, 32'h1);

    // R10 set wins over clear
    both_wr(1, 5'h0C, 32'h0000_0100, 1, 5'h08, 32'h0000_0100);
    peek_tx(5'h00, 32'h0000_01A0, "R10");
    peek_tx(5'h10, 32'h0, "R10");

    // R8 enable off masks interrupt
    tx_write(5'h18, 32'h0);
    rx_write(5'h08, 32'h0000_0020);
    peek_tx(5'h10, 32'h1, "R6");
    check("R8", FW'(tx_irq), '0);

    // R11 control bits
    tx_write(5'h1C, 32'hFFFF_FFFF);
    peek_tx(5'h1C, 32'h1, "R11");
    rx_write(5'h1C, 32'h3);
    peek_rx(5'h1C, 32'h1, "R11");

    // R12 unmapped / read-only
    peek_tx(5'h04, 32'h0, "R12");
    peek_rx(5'h0C, 32'h0, "R12");
    rx_write(5'h10, 32'h0);
    rx_write(5'h04, 32'hFFFF_FFFF);
    rx_write(5'h00, 32'h0);
    tx_write(5'h10, 32'h0);
    peek_rx(5'h10, 32'hFFFF_FFF1, "R12");
    peek_rx(5'h00, 32'h0000_0180, "R12");
    peek_tx(5'h10, 32'h1, "R12");
    idle();

    // random mix on both ports, compared every cycle
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1;
      tx_sel = $urandom % 2; tx_wr = $urandom % 2;
      tx_addr = pick_addr($urandom); tx_wdata = $urandom & $urandom;
      rx_sel = $urandom % 2; rx_wr = $urandom % 2;
      rx_addr = pick_addr($urandom); rx_wdata = $urandom | $urandom;
    end
    @(posedge clk); #1 idle();
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule